// File: doc/BRIEF.md
# SD Command Line Issuer and Response Checker

This block drives one SD bus command on the CMD line and then judges the card's reply. A single-cycle start strobe latches a 6-bit command index, a 32-bit argument, a 2-bit response type and two check enables. The block serialises a 48-bit command frame, one bit per clock. The frame's CRC7 is computed on the fly. The block then waits a bounded time for the response start bit. It shifts in a 48-bit or 136-bit response and checks the CRC and the index field, as selected. It reports completion with a one-cycle strobe and a set of error flags that stay valid until the next command is accepted.

The CMD line runs at the block clock. Any clock division belongs to the surrounding logic. An inhibit output tells software and sequencers when a new command may be issued. For the busy-signalling response type, the block also waits for DAT0 to go high after the reply.

Top module: `sdcmd_issuer`

## Requirements
- R1: After reset the block is idle: `inhibit_o`=0, `cmd_oe_o`=0, `cmd_o`=1, `done_o`=0, all error flags 0 and `rsp_o`=0.
- R2: A start strobe accepted while idle makes `cmd_oe_o` high for exactly 48 cycles, beginning in the next cycle. During those cycles `cmd_o` carries the frame MSB first: 0, 1, index[5:0], argument[31:0], CRC7, then 1. The CRC7 uses x^7+x^3+1 with a zero initial value over the first 40 frame bits. When `cmd_oe_o` is low, `cmd_o` is 1.
- R3: `inhibit_o` is 1 from the cycle after acceptance until completion. A start strobe while `inhibit_o` is 1 is ignored.
- R4: Response type 00 means no response. `done_o` pulses in the cycle right after the last frame bit, with all error flags 0.
- R5: After the frame, the block samples `cmd_i` for a start bit (0) on at most 64 clock edges. A 0 on the 64th edge is still accepted. If no 0 arrives, `done_o` pulses with `err_timeout_o`=1 and every other flag 0, and `rsp_o` is unchanged.
- R6: Response type 10 selects a 48-bit response. `rsp_o[31:0]` takes response bits 39..8 and `rsp_o[127:32]` is 0.
- R7: Response type 01 selects a 136-bit response. `rsp_o[119:0]` takes response bits 127..8 and `rsp_o[127:120]` is 0.
- R8: With the CRC check enabled, `err_crc_o` is set when bits 7..1 differ from the CRC7 of bits 47..8 (48-bit response) or of bits 127..8 (136-bit response). With the check disabled, `err_crc_o` stays 0.
- R9: With the index check enabled on a 48-bit response, `err_idx_o` is set when bits 45..40 differ from the issued index. The check never fires on a 136-bit response or when it is disabled.
- R10: `err_end_o` is set when response bit 0 is 0.
- R11: Response type 11 is a 48-bit response with a busy wait. Completion is held back until `dat0_i` is sampled high after the response.
- R12: `done_o` is a one-cycle pulse with `inhibit_o` already 0. For types 01 and 10 it occurs two cycles after the response end bit is on `cmd_i`. Flags and `rsp_o` stay unchanged until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the CMD bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Issue strobe, honoured when idle |
| cmd_idx_i | input | 6 | Command index |
| cmd_arg_i | input | 32 | Command argument |
| rsp_type_i | input | 2 | 00 none, 01 136-bit, 10 48-bit, 11 48-bit with busy |
| idx_chk_i | input | 1 | Enable response index check |
| crc_chk_i | input | 1 | Enable response CRC check |
| cmd_o | output | 1 | CMD line data out |
| cmd_oe_o | output | 1 | CMD line drive enable |
| cmd_i | input | 1 | CMD line data in |
| dat0_i | input | 1 | DAT0 level, low while the card is busy |
| inhibit_o | output | 1 | Command in progress |
| done_o | output | 1 | Completion strobe |
| err_timeout_o | output | 1 | No response start bit |
| err_end_o | output | 1 | Response end bit was 0 |
| err_crc_o | output | 1 | Response CRC mismatch |
| err_idx_o | output | 1 | Response index mismatch |
| rsp_o | output | 128 | Response payload register |

## Verification
The hardest corner is the edge of the response window. A start bit on the 64th sampling edge must be taken as a response, and the same bit one edge later must end in a timeout. The bench marks the first idle cycle after the frame by watching `cmd_oe_o` fall. It counts idle cycles from there before it drives the start bit, using delays 63 and 64 and the cycle-exact completion time. It also forces a second start strobe in the middle of a response. It then confirms that no second frame appears and that the index check still compares against the first command.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int CRC_W = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  localparam logic [1:0] RSP_NONE  = 2'b00;
  localparam logic [1:0] RSP_LONG  = 2'b01;
  localparam logic [1:0] RSP_SHORT = 2'b10;
  localparam logic [1:0] RSP_BUSY  = 2'b11;

  typedef enum logic [2:0] {ST_IDLE, ST_TX, ST_WAIT, ST_RX, ST_BUSY} st_e;

  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx import sdcmd_pkg::*; #(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [ARG_W-1:0] arg_i,
  output logic             cmd_o,
  output logic             oe_o,
  output logic             last_o
);
  localparam int BODY_W    = IDX_W + ARG_W + 2;
  localparam int FRAME_LEN = BODY_W + CRC_W + 1;
  localparam int CW        = $clog2(FRAME_LEN);
  localparam logic [CW-1:0] BODY_END = CW'(CRC_W + 1);

  logic              active;
  logic [CW-1:0]     cnt;
  logic [BODY_W-1:0] sh;
  logic [CRC_W-1:0]  crc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      crc    <= '0;
    end else if (load_i) begin
      active <= 1'b1;
      cnt    <= CW'(FRAME_LEN - 1);
      sh     <= {2'b01, idx_i, arg_i};
      crc    <= '0;
    end else if (active) begin
      if (cnt >= BODY_END) begin
        crc <= crc7_step(crc, sh[BODY_W-1]);
        sh  <= {sh[BODY_W-2:0], 1'b0};
      end else begin
        crc <= {crc[CRC_W-2:0], 1'b0};
      end
      cnt <= cnt - 1'b1;
      if (cnt == '0) active <= 1'b0;
    end
  end

  always_comb begin
    if (!active)               cmd_o = 1'b1;
    else if (cnt >= BODY_END)  cmd_o = sh[BODY_W-1];
    else if (cnt != '0)        cmd_o = crc[CRC_W-1];
    else                       cmd_o = 1'b1;
  end

  assign oe_o   = active;
  assign last_o = active && (cnt == '0);
endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx import sdcmd_pkg::*; #(
  parameter int IDX_W     = 6,
  parameter int SHORT_LEN = 48,
  parameter int LONG_LEN  = 136
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 long_i,
  input  logic                 cmd_i,
  output logic                 done_o,
  output logic                 end_bit_o,
  output logic [CRC_W-1:0]     crc_rx_o,
  output logic [CRC_W-1:0]     crc_calc_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [LONG_LEN-17:0] body_o
);
  localparam int KEEP_W = LONG_LEN - 8;
  localparam int CW     = $clog2(LONG_LEN);
  localparam logic [CW-1:0] CRC_LO = CW'(CRC_W + 1);
  localparam logic [CW-1:0] CRC_HI = CW'(LONG_LEN - 9);

  logic              active;
  logic [CW-1:0]     cnt;
  logic [KEEP_W-1:0] sh;
  logic [CRC_W-1:0]  crc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      crc    <= '0;
      done_o <= 1'b0;
    end else if (start_i) begin
      // start bit is 0: leaves a zero CRC state unchanged
      active <= 1'b1;
      cnt    <= long_i ? CW'(LONG_LEN - 2) : CW'(SHORT_LEN - 2);
      sh     <= '0;
      crc    <= '0;
      done_o <= 1'b0;
    end else if (active) begin
      sh <= {sh[KEEP_W-2:0], cmd_i};
      if (cnt >= CRC_LO && cnt <= CRC_HI) crc <= crc7_step(crc, cmd_i);
      cnt    <= cnt - 1'b1;
      active <= (cnt != '0);
      done_o <= (cnt == '0);
    end else begin
      done_o <= 1'b0;
    end
  end

  assign end_bit_o  = sh[0];
  assign crc_rx_o   = sh[CRC_W:1];
  assign crc_calc_o = crc;
  assign idx_o      = sh[SHORT_LEN-3 -: IDX_W];
  assign body_o     = sh[KEEP_W-1:8];
endmodule

// File: rtl/sdcmd_issuer.sv
module sdcmd_issuer import sdcmd_pkg::*; #(
  parameter int IDX_W    = 6,
  parameter int ARG_W    = 32,
  parameter int RSP_W    = 128,
  parameter int LONG_LEN = 136,
  parameter int TIMEOUT  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] cmd_idx_i,
  input  logic [ARG_W-1:0] cmd_arg_i,
  input  logic [1:0]       rsp_type_i,
  input  logic             idx_chk_i,
  input  logic             crc_chk_i,
  output logic             cmd_o,
  output logic             cmd_oe_o,
  input  logic             cmd_i,
  input  logic             dat0_i,
  output logic             inhibit_o,
  output logic             done_o,
  output logic             err_timeout_o,
  output logic             err_end_o,
  output logic             err_crc_o,
  output logic             err_idx_o,
  output logic [RSP_W-1:0] rsp_o
);
  localparam int SHORT_LEN = IDX_W + ARG_W + 2 + CRC_W + 1;
  localparam int BODY_W    = LONG_LEN - 16;
  localparam int TW        = $clog2(TIMEOUT);

  st_e              st;
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       type_q;
  logic             ichk_q, cchk_q;
  logic [TW-1:0]    tcnt;
  logic             accept, rx_start, tx_last, rx_done, rx_end;
  logic [CRC_W-1:0] rx_crc_field, rx_crc_calc;
  logic [IDX_W-1:0] rx_idx;
  logic [BODY_W-1:0] rx_body;

  assign accept   = (st == ST_IDLE) && start_i;
  assign rx_start = (st == ST_WAIT) && !cmd_i;

  sdcmd_tx #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_tx (
    .clk_i, .rst_ni,
    .load_i(accept), .idx_i(cmd_idx_i), .arg_i(cmd_arg_i),
    .cmd_o, .oe_o(cmd_oe_o), .last_o(tx_last)
  );

  sdcmd_rx #(.IDX_W(IDX_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_rx (
    .clk_i, .rst_ni,
    .start_i(rx_start), .long_i(type_q == RSP_LONG), .cmd_i,
    .done_o(rx_done), .end_bit_o(rx_end), .crc_rx_o(rx_crc_field),
    .crc_calc_o(rx_crc_calc), .idx_o(rx_idx), .body_o(rx_body)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st            <= ST_IDLE;
      idx_q         <= '0;
      type_q        <= RSP_NONE;
      ichk_q        <= 1'b0;
      cchk_q        <= 1'b0;
      tcnt          <= '0;
      done_o        <= 1'b0;
      err_timeout_o <= 1'b0;
      err_end_o     <= 1'b0;
      err_crc_o     <= 1'b0;
      err_idx_o     <= 1'b0;
      rsp_o         <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        ST_IDLE: if (start_i) begin
          idx_q         <= cmd_idx_i;
          type_q        <= rsp_type_i;
          ichk_q        <= idx_chk_i;
          cchk_q        <= crc_chk_i;
          err_timeout_o <= 1'b0;
          err_end_o     <= 1'b0;
          err_crc_o     <= 1'b0;
          err_idx_o     <= 1'b0;
          st            <= ST_TX;
        end
        ST_TX: if (tx_last) begin
          tcnt <= '0;
          if (type_q == RSP_NONE) begin
            st     <= ST_IDLE;
            done_o <= 1'b1;
          end else begin
            st <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (!cmd_i) begin
            st <= ST_RX;
          end else if (tcnt == TW'(TIMEOUT - 1)) begin
            err_timeout_o <= 1'b1;
            done_o        <= 1'b1;
            st            <= ST_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_RX: if (rx_done) begin
          err_end_o <= !rx_end;
          err_crc_o <= cchk_q && (rx_crc_calc != rx_crc_field);
          err_idx_o <= ichk_q && (type_q != RSP_LONG) && (rx_idx != idx_q);
          rsp_o     <= (type_q == RSP_LONG) ? RSP_W'(rx_body) : RSP_W'(rx_body[ARG_W-1:0]);
          if (type_q == RSP_BUSY) begin
            st <= ST_BUSY;
          end else begin
            st     <= ST_IDLE;
            done_o <= 1'b1;
          end
        end
        ST_BUSY: if (dat0_i) begin
          st     <= ST_IDLE;
          done_o <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign inhibit_o = (st != ST_IDLE);
endmodule

// File: rtl/sdcmd_issuer_chk.sv
module sdcmd_issuer_chk #(
  parameter int RSP_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             cmd_o,
  input logic             cmd_oe_o,
  input logic             inhibit_o,
  input logic             done_o,
  input logic             err_timeout_o,
  input logic             err_end_o,
  input logic             err_crc_o,
  input logic             err_idx_o,
  input logic [RSP_W-1:0] rsp_o
);
  p_inhibit_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !inhibit_o |=> inhibit_o);

  p_start_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !inhibit_o |=> cmd_oe_o && !cmd_o);

  p_line_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_oe_o |-> cmd_o);

  p_drive_inside_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_oe_o |-> inhibit_o);

  p_done_release_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !inhibit_o);

  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_timeout_alone_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_timeout_o |-> !(err_end_o || err_crc_o || err_idx_o));

  p_result_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inhibit_o && !start_i |=> $stable({err_timeout_o, err_end_o, err_crc_o, err_idx_o, rsp_o}));
endmodule

bind sdcmd_issuer sdcmd_issuer_chk #(.RSP_W(RSP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cmd_o(cmd_o),
  .cmd_oe_o(cmd_oe_o), .inhibit_o(inhibit_o), .done_o(done_o),
  .err_timeout_o(err_timeout_o), .err_end_o(err_end_o),
  .err_crc_o(err_crc_o), .err_idx_o(err_idx_o), .rsp_o(rsp_o)
);

// File: tb/sdcmd_issuer_test.sv
`timescale 1ns/1ps
module sdcmd_issuer_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [5:0]   cmd_idx_i = '0;
  logic [31:0]  cmd_arg_i = '0;
  logic [1:0]   rsp_type_i = '0;
  logic         idx_chk_i = 1'b0, crc_chk_i = 1'b0;
  logic         cmd_o, cmd_oe_o;
  logic         cmd_i = 1'b1, dat0_i = 1'b1;
  logic         inhibit_o, done_o;
  logic         err_timeout_o, err_end_o, err_crc_o, err_idx_o;
  logic [127:0] rsp_o;

  int n_vec = 0, n_bad = 0;
  logic [127:0] last_rsp = '0;

  always #4 clk = ~clk;

  sdcmd_issuer uut (
    .clk_i(clk), .rst_ni, .start_i, .cmd_idx_i, .cmd_arg_i, .rsp_type_i,
    .idx_chk_i, .crc_chk_i, .cmd_o, .cmd_oe_o, .cmd_i, .dat0_i,
    .inhibit_o, .done_o, .err_timeout_o, .err_end_o, .err_crc_o,
    .err_idx_o, .rsp_o
  );

  task automatic chk(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // remainder of data*x^7 divided by x^7+x^3+1
  function automatic logic [6:0] crc_div(input logic [119:0] d, input int n);
    logic [7:0] r;
    r = '0;
    for (int i = n - 1; i >= -7; i--) begin
      r = {r[6:0], (i >= 0) ? d[i] : 1'b0};
      if (r[7]) r = r ^ 8'h89;
    end
    return r[6:0];
  endfunction

  function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] pay,
                                            input bit bad_crc, input bit bad_end);
    logic [39:0] body;
    logic [6:0]  c;
    body = {2'b00, idx, pay};
    c = crc_div(120'(body), 40) ^ (bad_crc ? 7'h01 : 7'h00);
    return 136'({body, c, !bad_end});
  endfunction

  function automatic logic [135:0] mk_long(input logic [119:0] content, input bit bad_crc);
    logic [6:0] c;
    c = crc_div(content, 120) ^ (bad_crc ? 7'h40 : 7'h00);
    return {8'b0011_1111, content, c, 1'b1};
  endfunction

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] typ,
                         input bit ichk, input bit cchk, input logic [135:0] rf, input int rlen,
                         input int dly, input int busy, input bit poke,
                         input bit e_to, input bit e_end, input bit e_crc, input bit e_idx,
                         input logic [127:0] e_rsp, input string tag);
    logic [47:0] got, exp_cmd;
    bit oe_ok;
    bit quiet;
    exp_cmd = {2'b01, idx, arg, crc_div(120'({2'b01, idx, arg}), 40), 1'b1};
    dat0_i = (typ == 2'b11) ? 1'b0 : 1'b1;
    @(negedge clk);
    cmd_idx_i = idx; cmd_arg_i = arg; rsp_type_i = typ;
    idx_chk_i = ichk; crc_chk_i = cchk; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(inhibit_o === 1'b1, {"R3 inhibit after start ", tag}, 136'(inhibit_o), 136'(1));
    oe_ok = 1'b1;
    got = '0;
    for (int i = 0; i < 48; i++) begin
      if (cmd_oe_o !== 1'b1) oe_ok = 1'b0;
      got = {got[46:0], cmd_o};
      @(negedge clk);
    end
    chk(got === exp_cmd, {"R2 command frame ", tag}, 136'(got), 136'(exp_cmd));
    chk(oe_ok && cmd_oe_o === 1'b0 && cmd_o === 1'b1, {"R2 drive window ", tag},
        136'({oe_ok, cmd_oe_o, cmd_o}), 136'(3'b101));
    if (typ == 2'b00) begin
      chk(done_o === 1'b1 && inhibit_o === 1'b0, {"R4 no-response completion ", tag},
          136'({done_o, inhibit_o}), 136'(2'b10));
    end else if (dly >= 64) begin
      quiet = 1'b1;
      for (int j = 0; j < 64; j++) begin
        if (done_o !== 1'b0) quiet = 1'b0;
        @(negedge clk);
      end
      chk(quiet && done_o === 1'b1, {"R5 timeout edge ", tag}, 136'({quiet, done_o}), 136'(2'b11));
    end else begin
      repeat (dly) @(negedge clk);
      for (int b = 0; b < rlen; b++) begin
        cmd_i = rf[rlen - 1 - b];
        if (poke && b == 10) begin start_i = 1'b1; cmd_idx_i = ~idx; end
        if (poke && b == 11) begin start_i = 1'b0; cmd_idx_i = idx; end
        @(negedge clk);
      end
      cmd_i = 1'b1;
      if (typ == 2'b11) begin
        quiet = 1'b1;
        for (int j = 0; j < busy; j++) begin
          @(negedge clk);
          if (done_o !== 1'b0 || inhibit_o !== 1'b1) quiet = 1'b0;
        end
        chk(quiet, {"R11 held while DAT0 low ", tag}, 136'(quiet), 136'(1));
        dat0_i = 1'b1;
        @(negedge clk);
        chk(done_o === 1'b1, {"R11 completion after DAT0 high ", tag}, 136'(done_o), 136'(1));
      end else begin
        @(negedge clk);
        chk(done_o === 1'b1 && inhibit_o === 1'b0, {"R12 completion timing ", tag},
            136'({done_o, inhibit_o}), 136'(2'b10));
      end
    end
    chk({err_timeout_o, err_end_o, err_crc_o, err_idx_o} === {e_to, e_end, e_crc, e_idx},
        {"R5 R8 R9 R10 flags ", tag}, 136'({err_timeout_o, err_end_o, err_crc_o, err_idx_o}),
        136'({e_to, e_end, e_crc, e_idx}));
    chk(rsp_o === e_rsp, {"R6 R7 response register ", tag}, 136'(rsp_o), 136'(e_rsp));
    last_rsp = e_rsp;
    @(negedge clk);
    chk(done_o === 1'b0 && cmd_oe_o === 1'b0 && rsp_o === e_rsp &&
        {err_timeout_o, err_end_o, err_crc_o, err_idx_o} === {e_to, e_end, e_crc, e_idx},
        {"R12 pulse and hold R3 ", tag}, 136'({done_o, cmd_oe_o}), 136'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0]  arg, pay;
    logic [119:0] content;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(inhibit_o === 0 && cmd_oe_o === 0 && cmd_o === 1 && done_o === 0 &&
        {err_timeout_o, err_end_o, err_crc_o, err_idx_o} === 4'b0 && rsp_o === '0,
        "R1 reset state", 136'({inhibit_o, cmd_oe_o, cmd_o, done_o}), 136'(4'b0010));

    // R6 R8 R9 sweep over every index, short response, both checks on
    for (int i = 0; i < 64; i++) begin
      arg = 32'(i) * 32'h9E37_79B9 ^ 32'h5A5A_0000;
      pay = ~arg ^ 32'(i << 7);
      run_cmd(6'(i), arg, 2'b10, 1, 1, mk_short(6'(i), pay, 0, 0), 48, i % 5, 0, 0,
              0, 0, 0, 0, 128'(pay), "R6 sweep");
    end

    // R4 no response
    for (int i = 0; i < 4; i++)
      run_cmd(6'(i * 17), 32'hC0DE_0000 + 32'(i), 2'b00, 1, 1, '0, 0, 0, 0, 0,
              0, 0, 0, 0, last_rsp, "R4");

    // R7 long responses, index check on but not applied to long
    for (int i = 0; i < 4; i++) begin
      content = {4{30'(i) * 30'h1234_567}};
      run_cmd(6'd2, 32'(i), 2'b01, 1, 1, mk_long(content, 0), 136, i * 7, 0, 0,
              0, 0, 0, 0, {8'h00, content}, "R7 R9 long");
    end
    run_cmd(6'd9, 32'h1, 2'b01, 0, 1, mk_long(120'hABC, 1), 136, 2, 0, 0,
            0, 0, 1, 0, {8'h00, 120'hABC}, "R8 long crc bad");

    // R8 CRC errors
    run_cmd(6'd17, 32'h0, 2'b10, 0, 1, mk_short(6'd17, 32'h1111, 1, 0), 48, 1, 0, 0,
            0, 0, 1, 0, 128'h1111, "R8 crc bad enabled");
    run_cmd(6'd17, 32'h0, 2'b10, 0, 0, mk_short(6'd17, 32'h2222, 1, 0), 48, 1, 0, 0,
            0, 0, 0, 0, 128'h2222, "R8 crc bad disabled");
    // R9 index errors
    run_cmd(6'd18, 32'h5, 2'b10, 1, 1, mk_short(6'd19, 32'h3333, 0, 0), 48, 0, 0, 0,
            0, 0, 0, 1, 128'h3333, "R9 idx bad enabled");
    run_cmd(6'd18, 32'h5, 2'b10, 0, 1, mk_short(6'd19, 32'h4444, 0, 0), 48, 0, 0, 0,
            0, 0, 0, 0, 128'h4444, "R9 idx bad disabled");
    // R10 end bit
    run_cmd(6'd24, 32'h7, 2'b10, 1, 1, mk_short(6'd24, 32'h5555, 0, 1), 48, 3, 0, 0,
            0, 1, 0, 0, 128'h5555, "R10 end bit");
    // R5 window edges
    run_cmd(6'd25, 32'h8, 2'b10, 1, 1, mk_short(6'd25, 32'h6666, 0, 0), 48, 63, 0, 0,
            0, 0, 0, 0, 128'h6666, "R5 last edge accepted");
    run_cmd(6'd25, 32'h9, 2'b10, 1, 1, '0, 0, 64, 0, 0,
            1, 0, 0, 0, 128'h6666, "R5 timeout");
    // R11 busy
    run_cmd(6'd7, 32'hA, 2'b11, 1, 1, mk_short(6'd7, 32'h7777, 0, 0), 48, 2, 20, 0,
            0, 0, 0, 0, 128'h7777, "R11 busy 20");
    run_cmd(6'd38, 32'hB, 2'b11, 1, 1, mk_short(6'd38, 32'h8888, 0, 0), 48, 0, 1, 0,
            0, 0, 0, 0, 128'h8888, "R11 busy 1");
    // R3 start ignored mid-response: index check must still use the first index
    run_cmd(6'd12, 32'hC, 2'b10, 1, 1, mk_short(6'd12, 32'h9999, 0, 0), 48, 1, 0, 1,
            0, 0, 0, 0, 128'h9999, "R3 ignored start");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule